// File: doc/BRIEF.md
# Three-Level DMA/CPU Memory Port Arbiter

This block picks, every clock cycle, the single owner of a shared internal memory port. Five DMA channels and the CPU compete for it. Each channel presents a request bit and a 2-bit priority code. Among the channels, the strongest requesting level wins. When several channels are tied at that level, a rotating pointer breaks the tie so that no tied channel waits forever.

The CPU contest depends on the level of the winning channel. A high-level channel always beats the CPU and a low-level channel always gives way to it. A normal-level channel shares the port with the CPU through a two-state fairness machine, so the DMA side wins at least every second contested cycle. The machine has two states. `FAIR_CPU_TURN` is the reset state, and in it the CPU takes a contested normal cycle. In `FAIR_DMA_TURN` the channel takes that cycle. The only transition flips the state, and it fires on a contested normal cycle. In every other cycle the state holds.

Grants are combinational from the request inputs and two pieces of registered state: the round-robin pointer and the fairness state. Reset is synchronous and active high.

Top module: `mem_port_arbiter`

## Requirements
- R1: In any cycle at most one of the six grant outputs (five channel grants and the CPU grant) is high.
- R2: A grant goes only to a requester that is asserting its request. With no request anywhere, no grant is issued.
- R3: Priority codes are `2'b10` high, `2'b01` normal and `2'b00` low, and `2'b11` is treated as high. The granted channel always belongs to the highest level present among the requesting channels.
- R4: Within the top level, the grant goes to the first requesting channel found by counting upward from the pointer and wrapping from channel 4 to channel 0. When a channel grant is issued and two or more channels shared the top level, the pointer moves to the channel after the granted one (4 wraps to 0). In every other cycle the pointer holds.
- R5: If the top requesting level is high and the CPU requests, the channel is granted and the CPU is not.
- R6: If the top requesting level is low and the CPU requests, the CPU is granted and no channel is.
- R7: A contested normal cycle is one where the CPU requests and the top requesting level is normal. In such a cycle the CPU wins in `FAIR_CPU_TURN` and the channel wins in `FAIR_DMA_TURN`, and the state then flips. No other cycle changes the state, so the CPU never wins two contested normal cycles in a row.
- R8: A lone CPU request is granted. When DMA channels request and the CPU does not, the selected channel is granted.
- R9: Reset sets the pointer to channel 0 and the fairness state to `FAIR_CPU_TURN`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dma_req | input | 5 | Request bit per DMA channel |
| dma_prio | input | 10 | Priority codes, bits [2i+1:2i] for channel i |
| cpu_req | input | 1 | CPU memory request |
| dma_gnt | output | 5 | One-hot channel grant |
| cpu_gnt | output | 1 | CPU grant |

## Verification
The assertions assume that the inputs are stable and known around each rising edge. They also assume that the priority code of a channel that is not requesting has no effect. Only this second point lets any of the four codes appear on an idle channel. The bench changes inputs only on the falling edge and holds them for a whole cycle. It sweeps every combination of the five request bits, the CPU request and all 1024 priority-code vectors, so each code, including `2'b11`, appears on idle channels as well as requesting ones. Directed sequences after fresh resets cover pointer rotation, the hold of the pointer on lone grants and the alternation under normal contention.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_NORM = 2'd1,
        LVL_HIGH = 2'd2
    } level_e;

    typedef enum logic {
        FAIR_CPU_TURN = 1'b0,
        FAIR_DMA_TURN = 1'b1
    } fair_state_e;

    // Upper bit set means high (both 2'b10 and 2'b11).
    function automatic level_e decode_level(input logic [1:0] code);
        if (code[1])
            return LVL_HIGH;
        else if (code[0])
            return LVL_NORM;
        else
            return LVL_LOW;
    endfunction

endpackage

// File: rtl/arb_level_select.sv
module arb_level_select
    import arb_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int LVL_W  = 2
) (
    input  logic [NUM_CH-1:0]       req,
    input  logic [NUM_CH*LVL_W-1:0] prio,
    output level_e                  top_lvl,
    output logic [NUM_CH-1:0]       cand,
    output logic                    any_req
);

    logic [NUM_CH-1:0] hi_mask;
    logic [NUM_CH-1:0] nm_mask;
    logic [NUM_CH-1:0] lo_mask;

    // Sort every requesting channel into one of three level masks.
    always_comb begin
        hi_mask = '0;
        nm_mask = '0;
        lo_mask = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (req[i]) begin
                unique case (decode_level(prio[i*LVL_W +: 2]))
                    LVL_HIGH: hi_mask[i] = 1'b1;
                    LVL_NORM: nm_mask[i] = 1'b1;
                    default:  lo_mask[i] = 1'b1;
                endcase
            end
        end
    end

    // The strongest non-empty mask gives the top level and the candidates.
    always_comb begin
        any_req = |req;
        if (|hi_mask) begin
            top_lvl = LVL_HIGH;
            cand    = hi_mask;
        end else if (|nm_mask) begin
            top_lvl = LVL_NORM;
            cand    = nm_mask;
        end else begin
            top_lvl = LVL_LOW;
            cand    = lo_mask;
        end
    end

endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int NUM_CH = 5,
    parameter int IDX_W  = 3
) (
    input  logic [NUM_CH-1:0] cand,
    input  logic [IDX_W-1:0]  ptr,
    output logic [NUM_CH-1:0] onehot,
    output logic [IDX_W-1:0]  idx,
    output logic              valid
);

    // Scan upward from the pointer and wrap; the first candidate found wins.
    always_comb begin
        onehot = '0;
        idx    = '0;
        valid  = 1'b0;
        for (int k = 0; k < NUM_CH; k++) begin
            int p;
            p = int'(ptr) + k;
            if (p >= NUM_CH)
                p = p - NUM_CH;
            if (!valid && cand[p]) begin
                valid     = 1'b1;
                onehot[p] = 1'b1;
                idx       = IDX_W'(p);
            end
        end
    end

endmodule

// File: rtl/arb_fair_fsm.sv
module arb_fair_fsm
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic contest,
    output logic dma_turn
);

    fair_state_e state_q;
    fair_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= FAIR_CPU_TURN;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FAIR_CPU_TURN: if (contest) state_d = FAIR_DMA_TURN;
            FAIR_DMA_TURN: if (contest) state_d = FAIR_CPU_TURN;
            default:       state_d = FAIR_CPU_TURN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            FAIR_DMA_TURN: dma_turn = 1'b1;
            default:       dma_turn = 1'b0;
        endcase
    end

    AST_FAIR_FLIP: assert property (@(posedge clk) disable iff (rst)
        contest |=> (state_q != $past(state_q))); // R7
    AST_FAIR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !contest |=> $stable(state_q)); // R7
    AST_FAIR_RESET: assert property (@(posedge clk)
        rst |=> (state_q == FAIR_CPU_TURN)); // R9

endmodule

// File: rtl/mem_port_arbiter.sv
module mem_port_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int LVL_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CH-1:0]       dma_req,
    input  logic [NUM_CH*LVL_W-1:0] dma_prio,
    input  logic                    cpu_req,
    output logic [NUM_CH-1:0]       dma_gnt,
    output logic                    cpu_gnt
);

    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CH - 1);

    level_e            top_lvl;
    logic [NUM_CH-1:0] cand;
    logic              any_dma;
    logic [NUM_CH-1:0] pick_oh;
    logic [IDX_W-1:0]  pick_idx;
    logic              pick_vld;
    logic [IDX_W-1:0]  ptr_q;
    logic              dma_turn;
    logic              contest_norm;
    logic              dma_wins;
    logic              tied;

    arb_level_select #(.NUM_CH(NUM_CH), .LVL_W(LVL_W)) u_level (
        .req     (dma_req),
        .prio    (dma_prio),
        .top_lvl (top_lvl),
        .cand    (cand),
        .any_req (any_dma)
    );

    arb_rr_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
        .cand   (cand),
        .ptr    (ptr_q),
        .onehot (pick_oh),
        .idx    (pick_idx),
        .valid  (pick_vld)
    );

    assign contest_norm = cpu_req && any_dma && (top_lvl == LVL_NORM);

    arb_fair_fsm u_fair (
        .clk      (clk),
        .rst      (rst),
        .contest  (contest_norm),
        .dma_turn (dma_turn)
    );

    // CPU-versus-DMA decision, driven by the level of the top candidates.
    always_comb begin
        if (!any_dma) begin
            dma_wins = 1'b0;
        end else if (!cpu_req) begin
            dma_wins = 1'b1;
        end else begin
            unique case (top_lvl)
                LVL_HIGH: dma_wins = 1'b1;
                LVL_NORM: dma_wins = dma_turn;
                default:  dma_wins = 1'b0;
            endcase
        end
    end

    always_comb begin
        dma_gnt = (dma_wins && pick_vld) ? pick_oh : '0;
        cpu_gnt = cpu_req && !dma_wins;
    end

    assign tied = ($countones(cand) > 1);

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (dma_wins && pick_vld && tied)
            ptr_q <= (pick_idx == LAST_IDX) ? '0 : pick_idx + 1'b1;
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dma_gnt, cpu_gnt})); // R1
    AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        ((dma_gnt & ~dma_req) == '0) && !(cpu_gnt && !cpu_req)); // R2
    AST_IDLE_NO_GNT: assert property (@(posedge clk) disable iff (rst)
        (!(|dma_req) && !cpu_req) |-> (!(|dma_gnt) && !cpu_gnt)); // R2
    AST_GNT_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        (|dma_gnt) |-> ((dma_gnt & cand) != '0)); // R3
    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
        ptr_q <= LAST_IDX); // R4
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !((|dma_gnt) && tied) |=> $stable(ptr_q)); // R4
    AST_HIGH_BEATS_CPU: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && any_dma && top_lvl == LVL_HIGH) |-> (!cpu_gnt && (|dma_gnt))); // R5
    AST_LOW_YIELDS: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && any_dma && top_lvl == LVL_LOW) |-> (cpu_gnt && !(|dma_gnt))); // R6
    AST_NORM_NOT_TWICE: assert property (@(posedge clk) disable iff (rst)
        (contest_norm && cpu_gnt) |=> !(contest_norm && cpu_gnt)); // R7
    AST_SOLO_SERVED: assert property (@(posedge clk) disable iff (rst)
        ((any_dma && !cpu_req) |-> (|dma_gnt)) and ((cpu_req && !any_dma) |-> cpu_gnt)); // R8
    AST_PTR_RESET: assert property (@(posedge clk)
        rst |=> (ptr_q == '0)); // R9

endmodule

// File: tb/mem_port_arbiter_test.sv
`timescale 1ns/1ps
module mem_port_arbiter_test;

    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] dma_req = '0;
    logic [2*N-1:0] dma_prio = '0;
    logic         cpu_req = 1'b0;
    logic [N-1:0] dma_gnt;
    logic         cpu_gnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench-side state, advanced from the requirements.
    int m_ptr = 0;
    bit m_tog = 1'b0;

    always #5 clk = ~clk;

    mem_port_arbiter uut (
        .clk      (clk),
        .rst      (rst),
        .dma_req  (dma_req),
        .dma_prio (dma_prio),
        .cpu_req  (cpu_req),
        .dma_gnt  (dma_gnt),
        .cpu_gnt  (cpu_gnt)
    );

    task automatic chk(input string tag, input logic [N-1:0] eg, input logic ec);
        checks++;
        if (dma_gnt !== eg || cpu_gnt !== ec) begin
            fails++;
            $display("FAIL %s: dma_gnt=%b cpu_gnt=%b expected dma_gnt=%b cpu_gnt=%b",
                     tag, dma_gnt, cpu_gnt, eg, ec);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        dma_req = '0;
        cpu_req = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        m_ptr = 0;
        m_tog = 1'b0;
    endtask

    // Apply inputs at the falling edge, then compare before the next rising edge.
    task automatic step(input logic [N-1:0] r, input logic [2*N-1:0] p, input logic c,
                        input string tag, input logic [N-1:0] eg, input logic ec);
        @(negedge clk);
        dma_req  = r;
        dma_prio = p;
        cpu_req  = c;
        #2;
        chk(tag, eg, ec);
    endtask

    function automatic int lvl_of(input logic [1:0] code);
        return code[1] ? 2 : (code[0] ? 1 : 0);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R9: after reset, pointer at 0: five tied normal channels give channel 0.
        do_reset();
        step(5'b11111, 10'b01_01_01_01_01, 1'b0, "R9 pointer reset", 5'b00001, 1'b0);
        // R9: fairness starts in the CPU turn.
        do_reset();
        step(5'b00100, 10'b00_00_01_00_00, 1'b1, "R9 fair reset", 5'b00000, 1'b1);
        step(5'b00100, 10'b00_00_01_00_00, 1'b1, "R7 second contest", 5'b00100, 1'b0);
        step(5'b00100, 10'b00_00_01_00_00, 1'b1, "R7 third contest", 5'b00000, 1'b1);
        // R7: uncontested normal cycle leaves the turn alone (DMA turn pending).
        step(5'b00100, 10'b00_00_01_00_00, 1'b0, "R8 dma alone", 5'b00100, 1'b0);
        step(5'b00010, 10'b00_00_00_01_00, 1'b1, "R7 turn held", 5'b00010, 1'b0);
        // R3: code 2'b11 counts as high and beats normal, even against CPU (R5).
        do_reset();
        step(5'b01001, 10'b00_11_00_00_01, 1'b1, "R3 code11 high", 5'b01000, 1'b0);
        // R6: low against CPU.
        step(5'b10000, 10'b00_00_00_00_00, 1'b1, "R6 low yields", 5'b00000, 1'b1);
        // R2: nothing requesting.
        step(5'b00000, 10'b11_11_11_11_11, 1'b0, "R2 idle", 5'b00000, 1'b0);
        // R4: rotation through five tied low channels.
        do_reset();
        for (int k = 0; k < 6; k++)
            step(5'b11111, 10'b0, 1'b0, "R4 rotate", 5'(1 << (k % N)), 1'b0);
        // R4: a lone grant does not move the pointer.
        do_reset();
        step(5'b01000, 10'b00_01_00_00_00, 1'b0, "R4 lone grant", 5'b01000, 1'b0);
        step(5'b11111, 10'b01_01_01_01_01, 1'b0, "R4 pointer held", 5'b00001, 1'b0);

        // Exhaustive sweep from a fresh reset with a running model.
        do_reset();
        for (int p = 0; p < 1024; p++) begin
            for (int r = 0; r < 32; r++) begin
                for (int c = 0; c < 2; c++) begin
                    int lv[N];
                    int top;
                    int cnt;
                    int pick;
                    bit any;
                    bit dwin;
                    logic [N-1:0] eg;
                    logic ec;
                    string tag;
                    @(negedge clk);
                    dma_req  = 5'(r);
                    dma_prio = 10'(p);
                    cpu_req  = c[0];
                    top = -1;
                    for (int i = 0; i < N; i++) begin
                        lv[i] = lvl_of(dma_prio[2*i +: 2]);
                        if (dma_req[i] && lv[i] > top) top = lv[i];
                    end
                    any = (r != 0);
                    cnt = 0;
                    pick = -1;
                    for (int k = 0; k < N; k++) begin
                        int q;
                        q = (m_ptr + k) % N;
                        if (dma_req[q] && lv[q] == top) begin
                            cnt++;
                            if (pick < 0) pick = q;
                        end
                    end
                    if (!any) dwin = 1'b0;
                    else if (c == 0) dwin = 1'b1;
                    else if (top == 2) dwin = 1'b1;
                    else if (top == 1) dwin = m_tog;
                    else dwin = 1'b0;
                    eg = dwin ? 5'(1 << pick) : 5'b0;
                    ec = (c == 1) && !dwin;
                    if (!any && c == 0) tag = "R2 sweep idle";
                    else if (!any) tag = "R8 sweep cpu alone";
                    else if (c == 1 && top == 2) tag = "R5 sweep high vs cpu";
                    else if (c == 1 && top == 0) tag = "R6 sweep low vs cpu";
                    else if (c == 1) tag = "R7 sweep normal vs cpu";
                    else if (cnt > 1) tag = "R4 sweep tie";
                    else tag = "R3 sweep level";
                    #2;
                    chk(tag, eg, ec);
                    checks++;
                    if ($countones({dma_gnt, cpu_gnt}) > 1) begin
                        fails++;
                        $display("FAIL R1: grants=%b expected at most one high",
                                 {dma_gnt, cpu_gnt});
                    end
                    if (dwin && cnt > 1) m_ptr = (pick + 1) % N;
                    if (c == 1 && any && top == 1) m_tog = ~m_tog;
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule